// File: doc/BRIEF.md
# Exponential Backoff Spin Controller

This block sets the pace for retries of a contended atomic operation. It holds a backoff count. Each accepted retry request starts a spin whose length depends on that count. When the spin ends, the block pulses done. It then doubles the count for the next retry, unless the count has already gone past a fixed limit. A setup pulse returns the count to one before a new sequence of attempts begins.

There are two delay styles, and the mode input selects one for each spin. Loop mode counts down from the backoff count to zero and spends one fixed-length wait unit on every step, including the step at zero. Pause mode scales the count up by seven bit positions. It issues that value once as a pause request and then waits the length a pause counter would take. That counter has eight-cycle granularity, and a request too small to reach one tick stalls for a single cycle.

Top module: `backoff_spin_ctrl`

## Requirements
- R1: After reset busy_o, done_o and pause_vld_o are low and the backoff count is 1.
- R2: setup_i while idle loads the count with 1. A retry_i in that same cycle is ignored, so busy_o stays low.
- R3: An accepted retry_i (idle, setup_i low) raises busy_o on the next cycle. busy_o stays high through the cycle of done_o, which is a single-cycle pulse, and falls on the cycle after it.
- R4: retry_i while busy_o is high has no effect on the running spin or on the count.
- R5: With mode_i = 0 at acceptance (loop mode), busy_o is high for exactly (count + 1) * UNIT_CYCLES cycles (default 128).
- R6: With mode_i = 1 at acceptance (pause mode), pause_vld_o pulses in the first busy cycle with pause_val_o = count << 7. busy_o then lasts ((count << 7) >> 3) * 8 cycles, or 1 cycle if that shifted value is zero.
- R7: At the end of each spin the count doubles if it is at most LIMIT (default 4096). Otherwise it stays unchanged.
- R8: mode_i is sampled only at acceptance. Changes during a spin have no effect.
- R9: setup_i while busy_o is high is ignored.
- R10: pause_vld_o never rises for a loop-mode spin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setup_i | input | 1 | Reload the backoff count with 1 (honoured when idle) |
| retry_i | input | 1 | Request a backoff spin (honoured when idle) |
| mode_i | input | 1 | Delay style: 0 loop of wait units, 1 single pause request |
| busy_o | output | 1 | Spin in progress |
| done_o | output | 1 | Single-cycle pulse in the last busy cycle |
| pause_vld_o | output | 1 | Pause request strobe, first busy cycle of a pause-mode spin |
| pause_val_o | output | CNT_W+PAUSE_SHIFT | Pause request amount, count scaled up by PAUSE_SHIFT |

## Verification
The assertions assume that the count register can hold twice LIMIT, so a doubling never wraps. They also assume that setup_i and retry_i matter only while idle. The bench shrinks the unit length, limit and count width so that runs reach the saturation point, and it sizes CNT_W to hold the top reachable count. The stimulus toggles retry_i, mode_i and setup_i at random in the middle of spins and clears them at the first idle cycle, so the only requests accepted are the deliberate ones.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  typedef enum logic {
    SPIN_LOOP  = 1'b0,
    SPIN_PAUSE = 1'b1
  } spin_mode_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/backoff_count.sv
module backoff_count #(
  parameter int CNT_W = 14,
  parameter int LIMIT = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_one_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] Lim = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] One = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= One;
    else if (load_one_i) cnt_q <= One;
    else if (adv_i)      cnt_q <= (cnt_q > Lim) ? cnt_q : (cnt_q << 1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/backoff_load.sv
module backoff_load
  import backoff_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int UNIT_CYCLES = 128,
  parameter int PAUSE_SHIFT = 7,
  parameter int GRAN_SHIFT  = 3,
  parameter int MAJ_W       = 18,
  parameter int MIN_W       = 7,
  parameter int PV_W        = 21
) (
  input  spin_mode_e       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [MAJ_W-1:0] maj_o,
  output logic [MIN_W-1:0] min_rld_o,
  output logic [PV_W-1:0]  pause_val_o
);
  localparam logic [MIN_W-1:0] UnitRld = MIN_W'(UNIT_CYCLES - 1);
  localparam logic [MIN_W-1:0] GranRld = MIN_W'((1 << GRAN_SHIFT) - 1);

  logic [PV_W-1:0] ticks;

  assign pause_val_o = PV_W'(cnt_i) << PAUSE_SHIFT;
  assign ticks       = pause_val_o >> GRAN_SHIFT;

  always_comb begin
    if (mode_i == SPIN_LOOP) begin
      // count+1 units: major runs count..0
      maj_o     = MAJ_W'(cnt_i);
      min_rld_o = UnitRld;
    end else if (ticks == '0) begin
      maj_o     = '0;
      min_rld_o = '0;
    end else begin
      maj_o     = MAJ_W'(ticks - PV_W'(1));
      min_rld_o = GranRld;
    end
  end
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer #(
  parameter int MAJ_W = 18,
  parameter int MIN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MAJ_W-1:0] maj_i,
  input  logic [MIN_W-1:0] min_rld_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [MAJ_W-1:0] maj_q;
  logic [MIN_W-1:0] min_q, rld_q;
  logic             busy_q;

  assign done_o = busy_q && (maj_q == '0) && (min_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      maj_q  <= '0;
      min_q  <= '0;
      rld_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      maj_q  <= maj_i;
      min_q  <= min_rld_i;
      rld_q  <= min_rld_i;
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
      end else if (min_q != '0) begin
        min_q <= min_q - MIN_W'(1);
      end else begin
        maj_q <= maj_q - MAJ_W'(1);
        min_q <= rld_q;
      end
    end
  end
endmodule

// File: rtl/backoff_spin_ctrl.sv
module backoff_spin_ctrl
  import backoff_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int LIMIT       = 4096,
  parameter int UNIT_CYCLES = 128,
  parameter int PAUSE_SHIFT = 7,
  parameter int GRAN_SHIFT  = 3,
  localparam int PV_W       = CNT_W + PAUSE_SHIFT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            setup_i,
  input  logic            retry_i,
  input  logic            mode_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            pause_vld_o,
  output logic [PV_W-1:0] pause_val_o
);
  localparam int MAJ_W = max2(CNT_W, max2(PV_W - GRAN_SHIFT, 1));
  localparam int MIN_W = max2(max2($clog2(UNIT_CYCLES), GRAN_SHIFT), 1);

  logic             busy, done, start, load_one;
  logic [CNT_W-1:0] cnt;
  logic [MAJ_W-1:0] maj;
  logic [MIN_W-1:0] min_rld;
  logic [PV_W-1:0]  pv_d, pv_q;
  logic             pvld_q;
  spin_mode_e       mode;

  assign mode     = spin_mode_e'(mode_i);
  assign load_one = setup_i && !busy;
  assign start    = retry_i && !setup_i && !busy;

  backoff_count #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_count (
    .clk_i, .rst_ni, .load_one_i(load_one), .adv_i(done), .cnt_o(cnt)
  );

  backoff_load #(
    .CNT_W(CNT_W), .UNIT_CYCLES(UNIT_CYCLES), .PAUSE_SHIFT(PAUSE_SHIFT),
    .GRAN_SHIFT(GRAN_SHIFT), .MAJ_W(MAJ_W), .MIN_W(MIN_W), .PV_W(PV_W)
  ) u_load (
    .mode_i(mode), .cnt_i(cnt), .maj_o(maj), .min_rld_o(min_rld), .pause_val_o(pv_d)
  );

  backoff_timer #(.MAJ_W(MAJ_W), .MIN_W(MIN_W)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .maj_i(maj), .min_rld_i(min_rld),
    .busy_o(busy), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvld_q <= 1'b0;
      pv_q   <= '0;
    end else begin
      pvld_q <= start && (mode == SPIN_PAUSE);
      if (start) pv_q <= pv_d;
    end
  end

  assign busy_o      = busy;
  assign done_o      = done;
  assign pause_vld_o = pvld_q;
  assign pause_val_o = pv_q;
endmodule

// File: rtl/backoff_spin_chk.sv
module backoff_spin_chk #(
  parameter int CNT_W = 14,
  parameter int LIMIT = 4096
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             setup_i,
  input logic             retry_i,
  input logic             mode_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             pause_vld_o,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] Lim = CNT_W'(LIMIT);

  // R3
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R3
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && retry_i && !setup_i) |=> busy_o);
  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R2
  setup_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && setup_i) |=> (!busy_o && cnt_i == CNT_W'(1)));
  // R7
  double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cnt_i <= Lim) |=> (cnt_i == ($past(cnt_i) << 1)));
  // R7
  saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cnt_i > Lim) |=> $stable(cnt_i));
  // R9
  setup_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(cnt_i));
  // R10
  pause_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_vld_o |-> ($past(mode_i) && $past(retry_i) && $rose(busy_o)));
endmodule

bind backoff_spin_ctrl backoff_spin_chk #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .setup_i(setup_i), .retry_i(retry_i),
  .mode_i(mode_i), .busy_o(busy_o), .done_o(done_o),
  .pause_vld_o(pause_vld_o), .cnt_i(cnt)
);

// File: tb/backoff_spin_ctrl_tb.sv
`timescale 1ns/1ps
module backoff_spin_ctrl_tb;
  localparam int TB_CNT_W = 6;
  localparam int TB_LIMIT = 16;
  localparam int TB_UNIT  = 4;
  localparam int TB_PV_W  = TB_CNT_W + 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic setup_i = 1'b0, retry_i = 1'b0, mode_i = 1'b0;
  logic busy_o, done_o, pause_vld_o;
  logic [TB_PV_W-1:0] pause_val_o;

  int checks = 0, errors = 0;
  int exp_cnt = 1;

  always #2.5 clk_i = ~clk_i;

  backoff_spin_ctrl #(
    .CNT_W(TB_CNT_W), .LIMIT(TB_LIMIT), .UNIT_CYCLES(TB_UNIT)
  ) u_dut (
    .clk_i, .rst_ni, .setup_i, .retry_i, .mode_i,
    .busy_o, .done_o, .pause_vld_o, .pause_val_o
  );

  function automatic int exp_len(int c, bit m);
    int t;
    if (!m) return (c + 1) * TB_UNIT;
    t = (c << 7) >> 3;
    return (t == 0) ? 1 : t * 8;
  endfunction

  function automatic int nxt(int c);
    return (c > TB_LIMIT) ? c : 2 * c;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic spin(bit m, bit disturb, string tag);
    int n = 0, dpos = 0, pvn = 0, pvpos = 0, pval = 0;
    @(negedge clk_i);
    retry_i = 1'b1; mode_i = m;
    @(negedge clk_i);
    retry_i = 1'b0;
    check(busy_o, "R3 busy after accept", int'(busy_o), 1);
    while (busy_o && n < 100000) begin
      n++;
      if (done_o) dpos = n;
      if (pause_vld_o) begin pvn++; pvpos = n; pval = int'(pause_val_o); end
      if (disturb) begin
        retry_i = 1'($urandom_range(0, 1));
        mode_i  = 1'($urandom_range(0, 1));
        setup_i = ($urandom_range(0, 3) == 0);
      end
      @(negedge clk_i);
    end
    retry_i = 1'b0; setup_i = 1'b0;
    check(n == exp_len(exp_cnt, m), m ? "R6 pause length" : "R5 loop length",
          n, exp_len(exp_cnt, m));
    if (n != exp_len(exp_cnt, m)) $display("  (context %s, count %0d)", tag, exp_cnt);
    check(dpos == n, "R3 done in last busy cycle", dpos, n);
    if (m) begin
      check(pvn == 1 && pvpos == 1, "R6 pause strobe first cycle", pvn * 100 + pvpos, 101);
      check(pval == (exp_cnt << 7), "R6 pause value", pval, exp_cnt << 7);
    end else begin
      check(pvn == 0, "R10 no pause strobe in loop mode", pvn, 0);
    end
    exp_cnt = nxt(exp_cnt);
  endtask

  task automatic do_setup(bit with_retry);
    @(negedge clk_i);
    setup_i = 1'b1; retry_i = with_retry;
    @(negedge clk_i);
    setup_i = 1'b0; retry_i = 1'b0;
    check(!busy_o, "R2 setup blocks retry", int'(busy_o), 0);
    exp_cnt = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !pause_vld_o, "R1 reset outputs",
          int'({busy_o, done_o, pause_vld_o}), 0);
    rst_ni = 1'b1;
    // R1: first spin uses count 1
    spin(1'b0, 1'b0, "R1");
    // R7: climb to the limit and past it, then saturate
    for (int i = 0; i < 6; i++) spin(1'b0, 1'b0, "R7");
    spin(1'b1, 1'b0, "R7 saturated pause");
    // R2
    do_setup(1'b1);
    spin(1'b1, 1'b0, "R2 after setup");
    // R4 R8 R9: disturbed spins
    spin(1'b0, 1'b1, "R8 disturbed loop");
    spin(1'b1, 1'b1, "R9 disturbed pause");
    do_setup(1'b0);
    for (int i = 0; i < 25; i++) begin
      if ($urandom_range(0, 3) == 0) do_setup(1'($urandom_range(0, 1)));
      spin(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule